// File: doc/BRIEF.md
# Completion Poll Controller for Flash Program and Erase

This block runs on the host side of a parallel flash interface once a program or erase command sequence has been fully written. It reads one status address over and over and watches the completion flag bit of each returned word. While that bit is the complement of its final value, the memory is still busy. When the bit first shows its final value, the controller issues one extra read. It does this because the remaining bits may not yet be settled at the moment the flag changes. The word from that extra read is the trusted result.

The caller supplies four things with a start pulse: whether the operation is an erase, the data that was programmed, the address to poll, and a limit on status reads. For a program, the final flag value is the flag bit of the programmed data. For an erase, it is 1. For an erase, the caller must choose a poll address inside a sector being erased that is not protected.

The controller talks to the memory through a request/acknowledge read port. It ends each operation with a one-cycle done pulse and exactly one of three outcomes:
- ok: the operation completed;
- mismatch: a program completed, but the confirmed word differs from the intended data;
- timeout: the flag never reached its final value within the limit.

Top module: `cmpl_poll_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `rd_req_o`, `busy_o`, `done_o`, `ok_o`, `timeout_o` and `mismatch_o` are all 0.
- R2: A start pulse is accepted only while `busy_o` is 0. Acceptance latches the poll address, the operation kind and the data, and raises `busy_o` and `rd_req_o` on the next cycle. A start pulse while busy changes neither the poll address nor the expected flag value.
- R3: `rd_req_o` stays high with `rd_addr_o` equal to the latched address until `rd_ack_i` is sampled high. Each sampled acknowledge completes one read, and `rd_data_i` is taken in that cycle. If more reads are needed, the request stays high for the next read.
- R4: The expected flag value is bit 7 of the programmed data for a program (`erase_i`=0) and 1 for an erase (`erase_i`=1). A status word whose bit 7 differs from it leads to a further status read.
- R5: The first status word whose bit 7 equals the expected value is followed by exactly one confirm read. The outcome is decided from the confirm word alone.
- R6: `done_o` is high for exactly one cycle, the cycle after the acknowledge of the final read. In that cycle `busy_o` and `rd_req_o` are 0.
- R7: For a program, `mismatch_o` is 1 and `ok_o` is 0 when the confirm word differs from `wdata_i` in any bit; otherwise `ok_o` is 1. For an erase, the confirm word always gives `ok_o` = 1.
- R8: If `limit_i` status reads in a row all miss (a limit of 0 acts as 1), the operation ends with `timeout_o` = 1 and no confirm read is made.
- R9: `result_o` holds the last word read, and the outcome flags hold their values until the next start is accepted, which clears them.
- R10: The confirm read does not count against the limit, so a match on the last permitted status read still ends with a confirm read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| erase_i | input | 1 | 1 = erase operation, 0 = program operation |
| addr_i | input | AW | Status address to poll |
| wdata_i | input | DW | Programmed data (program only) |
| limit_i | input | CW | Maximum number of status reads |
| rd_req_o | output | 1 | Read request to the memory interface |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge; data valid in this cycle |
| rd_data_i | input | DW | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Operation completed and verified |
| timeout_o | output | 1 | Poll limit reached |
| mismatch_o | output | 1 | Program confirm word differs from intended data |
| result_o | output | DW | Last word read from memory |

## Verification
The results arrive at fixed delays:
- `rd_req_o` and `busy_o` rise one clock after the edge that samples the start pulse.
- A new read request follows in the cycle after each acknowledge edge.
- `done_o`, the flags and `result_o` change one clock after the edge that samples the final acknowledge.

The bench drives inputs and samples outputs on falling edges. It presents each acknowledge half a cycle ahead of the rising edge that consumes it, and checks the completion outputs at the first falling edge after that rising edge. It checks the pulse's end one falling edge later. The table also counts acknowledges per operation, so a missing or extra confirm read shows up as a wrong count.

// File: rtl/cmpl_poll_pkg.sv
package cmpl_poll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POLL = 2'd1,
    ST_CONF = 2'd2
  } poll_st_e;
endpackage

// File: rtl/poll_counter.sv
// Counts status reads and flags the last permitted one.
module poll_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] limit_i,
  input  logic          inc_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q, lim_q;
  logic [CW:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  // A limit of 0 behaves as 1: the first read is already the last.
  assign last_o  = cnt_nxt >= {1'b0, lim_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      lim_q <= limit_i;
    end else if (inc_i) begin
      cnt_q <= cnt_nxt[CW-1:0];
    end
  end
endmodule

// File: rtl/poll_fsm.sv
// Sequencer: idle -> status polling -> confirm read -> idle.
module poll_fsm
  import cmpl_poll_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     ack_i,
  input  logic     hit_i,
  input  logic     last_i,
  output poll_st_e state_o,
  output logic     accept_o,
  output logic     fin_conf_o,
  output logic     fin_to_o
);
  poll_st_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    accept_o   = 1'b0;
    fin_conf_o = 1'b0;
    fin_to_o   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          state_d  = ST_POLL;
        end
      end
      ST_POLL: begin
        if (ack_i) begin
          if (hit_i) begin
            state_d = ST_CONF;
          end else if (last_i) begin
            fin_to_o = 1'b1;
            state_d  = ST_IDLE;
          end
        end
      end
      ST_CONF: begin
        if (ack_i) begin
          fin_conf_o = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/poll_judge.sv
// Registers the outcome: result word, flags and the done pulse.
module poll_judge #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic          fire_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          fin_conf_i,
  input  logic          fin_to_i,
  input  logic          is_prog_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic          ok_o,
  output logic          timeout_o,
  output logic          mismatch_o,
  output logic [DW-1:0] result_o
);
  logic bad_word;
  assign bad_word = is_prog_i && (rdata_i != wdata_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o     <= 1'b0;
      ok_o       <= 1'b0;
      timeout_o  <= 1'b0;
      mismatch_o <= 1'b0;
      result_o   <= '0;
    end else begin
      done_o <= fin_conf_i | fin_to_i;
      if (accept_i) begin
        ok_o       <= 1'b0;
        timeout_o  <= 1'b0;
        mismatch_o <= 1'b0;
      end else if (fin_conf_i) begin
        ok_o       <= !bad_word;
        mismatch_o <= bad_word;
      end else if (fin_to_i) begin
        timeout_o  <= 1'b1;
      end
      if (fire_i) result_o <= rdata_i;
    end
  end
endmodule

// File: rtl/cmpl_poll_ctrl.sv
module cmpl_poll_ctrl
  import cmpl_poll_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int FLAG_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          erase_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [CW-1:0] limit_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          ok_o,
  output logic          timeout_o,
  output logic          mismatch_o,
  output logic [DW-1:0] result_o
);
  poll_st_e      state;
  logic          accept, fin_conf, fin_to, last, hit, fire;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          prog_q, exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      prog_q  <= 1'b0;
      exp_q   <= 1'b0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      prog_q  <= !erase_i;
      exp_q   <= erase_i | wdata_i[FLAG_BIT];
    end
  end

  assign rd_req_o  = (state == ST_POLL) || (state == ST_CONF);
  assign rd_addr_o = addr_q;
  assign busy_o    = (state != ST_IDLE);
  assign fire      = rd_req_o && rd_ack_i;
  assign hit       = (rd_data_i[FLAG_BIT] == exp_q);

  poll_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ack_i     (rd_ack_i),
    .hit_i     (hit),
    .last_i    (last),
    .state_o   (state),
    .accept_o  (accept),
    .fin_conf_o(fin_conf),
    .fin_to_o  (fin_to)
  );

  poll_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .limit_i(limit_i),
    .inc_i  (fire && (state == ST_POLL)),
    .last_o (last)
  );

  poll_judge #(.DW(DW)) u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept),
    .fire_i    (fire),
    .rdata_i   (rd_data_i),
    .fin_conf_i(fin_conf),
    .fin_to_i  (fin_to),
    .is_prog_i (prog_q),
    .wdata_i   (wdata_q),
    .done_o    (done_o),
    .ok_o      (ok_o),
    .timeout_o (timeout_o),
    .mismatch_o(mismatch_o),
    .result_o  (result_o)
  );
endmodule

// File: rtl/cmpl_poll_chk.sv
module cmpl_poll_chk #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_ack_i,
  input logic [DW-1:0] rd_data_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          ok_o,
  input logic          timeout_o,
  input logic          mismatch_o,
  input logic [DW-1:0] result_o
);
  assert_idle_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_req_o);

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && rd_req_o));

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && $past(rd_req_o)) |-> $stable(rd_addr_o));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(rd_ack_i && rd_req_o) && !busy_o));

  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones({ok_o, timeout_o, mismatch_o}) == 1));

  assert_result_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o == $past(rd_data_i)));
endmodule

bind cmpl_poll_ctrl cmpl_poll_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .rd_req_o  (rd_req_o),
  .rd_addr_o (rd_addr_o),
  .rd_ack_i  (rd_ack_i),
  .rd_data_i (rd_data_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .ok_o      (ok_o),
  .timeout_o (timeout_o),
  .mismatch_o(mismatch_o),
  .result_o  (result_o)
);

// File: tb/tb_cmpl_poll_ctrl.sv
module tb_cmpl_poll_ctrl;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int CW = 16;

  typedef struct packed {
    logic          erase;
    logic [15:0]   wdata;
    logic [15:0]   limit;
    logic [5:0][15:0] w;     // w[i] is returned by read i (clamped at 5)
    logic [3:0]    reads;
    logic [2:0]    flags;    // {timeout, mismatch, ok}
    logic [15:0]   res;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    // R5: stale low bits on the first match, confirm word is final
    '{1'b0, 16'h1280, 16'd10, {16'h1280,16'h1280,16'h1280,16'h0280,16'h0000,16'h0000}, 4'd4, 3'b001, 16'h1280},
    // R4: program with flag 0, complement seen first
    '{1'b0, 16'h0055, 16'd10, {16'h0055,16'h0055,16'h0055,16'h0055,16'h0055,16'h0080}, 4'd3, 3'b001, 16'h0055},
    // R4/R7: erase expects flag 1
    '{1'b1, 16'h0000, 16'd10, {16'hFFFF,16'hFFFF,16'hFF80,16'h0000,16'h0000,16'h0000}, 4'd5, 3'b001, 16'hFFFF},
    // R7: program confirm word differs
    '{1'b0, 16'h00AA, 16'd10, {16'h00A2,16'h00A2,16'h00A2,16'h00A2,16'h00A0,16'h0000}, 4'd3, 3'b010, 16'h00A2},
    // R8: limit 3, never matches
    '{1'b0, 16'h0080, 16'd3,  {16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000}, 4'd3, 3'b100, 16'h0000},
    // R8: limit 0 acts as 1
    '{1'b1, 16'h0000, 16'd0,  {16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000}, 4'd1, 3'b100, 16'h0000},
    // R10: limit 1, immediate match still confirmed
    '{1'b1, 16'h0000, 16'd1,  {16'hFFFF,16'hFFFF,16'hFFFF,16'hFFFF,16'hFFFF,16'hFFFF}, 4'd2, 3'b001, 16'hFFFF},
    // R10: match on the last permitted read
    '{1'b0, 16'h0080, 16'd3,  {16'h0080,16'h0080,16'h0080,16'h0080,16'h0000,16'h0000}, 4'd4, 3'b001, 16'h0080}
  };

  logic          clk, rst_n, start_i, erase_i, rd_ack_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i, rd_data_i;
  logic [CW-1:0] limit_i;
  logic          rd_req_o, busy_o, done_o, ok_o, timeout_o, mismatch_o;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] result_o;

  int checks = 0;
  int fails  = 0;

  cmpl_poll_ctrl #(.AW(AW), .DW(DW), .CW(CW), .FLAG_BIT(7)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .erase_i(erase_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .limit_i(limit_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o),
    .timeout_o(timeout_o), .mismatch_o(mismatch_o), .result_o(result_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input logic cond, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  // Runs one operation against a scripted memory.
  // lat = wait cycles before each acknowledge; poke = start pulse while busy.
  task automatic run_vec(input int idx, input int lat, input bit poke);
    vec_t v = VECS[idx];
    logic [AW-1:0] a = AW'(20'h01000 + idx * 20'h40);
    int reads = 0;
    int wc = 0;
    int bad_addr = 0;
    bit seen = 0;
    @(negedge clk);
    start_i = 1'b1; erase_i = v.erase; wdata_i = v.wdata; limit_i = v.limit; addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
    // R2 R9: accepted start raises busy/request and clears old flags
    chk(busy_o && rd_req_o && !ok_o && !timeout_o && !mismatch_o, "R2/R9 start",
        {27'd0, busy_o, rd_req_o, ok_o, timeout_o, mismatch_o}, 32'h18);
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (done_o) begin
        seen = 1;
        break;
      end
      if (poke && cyc == 0) begin
        start_i = 1'b1; erase_i = ~v.erase; addr_i = a ^ 20'h00FFF;
      end else begin
        start_i = 1'b0;
      end
      rd_ack_i = 1'b0;
      if (rd_req_o) begin
        if (rd_addr_o != a) bad_addr++;
        if (wc >= lat) begin
          rd_ack_i  = 1'b1;
          rd_data_i = v.w[(reads > 5) ? 5 : reads];
          reads++;
          wc = 0;
        end else begin
          wc++;
        end
      end
      @(negedge clk);
    end
    rd_ack_i = 1'b0;
    start_i  = 1'b0;
    chk(seen, "R6 done seen", {31'd0, seen}, 1);
    chk(bad_addr == 0, "R2/R3 address held", bad_addr, 0);
    chk({timeout_o, mismatch_o, ok_o} == v.flags, "R7/R8 outcome",
        {29'd0, timeout_o, mismatch_o, ok_o}, {29'd0, v.flags});
    chk(result_o == v.res, "R9 result", {16'd0, result_o}, {16'd0, v.res});
    chk(reads == int'(v.reads), "R5/R10 read count", reads, v.reads);
    chk(!busy_o && !rd_req_o, "R6 idle at done", {30'd0, busy_o, rd_req_o}, 0);
    @(negedge clk);
    chk(!done_o, "R6 single-cycle done", {31'd0, done_o}, 0);
    chk({timeout_o, mismatch_o, ok_o} == v.flags, "R9 flags held",
        {29'd0, timeout_o, mismatch_o, ok_o}, {29'd0, v.flags});
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; erase_i = 1'b0; addr_i = '0; wdata_i = '0;
    limit_i = '0; rd_ack_i = 1'b0; rd_data_i = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk(!rd_req_o && !busy_o && !done_o && !ok_o && !timeout_o && !mismatch_o,
        "R1 in reset", {26'd0, rd_req_o, busy_o, done_o, ok_o, timeout_o, mismatch_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!rd_req_o && !busy_o && !done_o, "R1 after release",
        {29'd0, rd_req_o, busy_o, done_o}, 0);

    for (int i = 0; i < NV; i++) run_vec(i, 0, 1'b0);

    // R3: wait states before each acknowledge
    run_vec(0, 3, 1'b0);
    run_vec(3, 2, 1'b0);
    // R2: start while busy ignored (address and expected flag unchanged)
    run_vec(1, 1, 1'b1);

    // R1: reset in the middle of polling returns to idle
    @(negedge clk);
    start_i = 1'b1; erase_i = 1'b1; limit_i = 16'd50; addr_i = 20'h00123;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(rd_req_o, "R3 request held without ack", {31'd0, rd_req_o}, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!rd_req_o && !busy_o && !done_o && !timeout_o, "R1 mid-op reset",
        {28'd0, rd_req_o, busy_o, done_o, timeout_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_vec(6, 0, 1'b0);
    summary();
  end
endmodule